// File: doc/BRIEF.md
# Float-to-Fixed Converter

This block turns one binary floating-point word into a two's-complement fixed-point word. The number of fraction bits in the result, which sets where the binary point sits, can be fixed when the block is built or supplied with each conversion. The block is used at the boundary between a processor's floating-point memory image and a fixed-point coprocessor. Each word read from memory passes through it once, and the coprocessor receives integers that it can add and multiply directly.

The input splits into three fields. The sign is the MSB, the exponent is the next `EXP_W` bits, and the mantissa is the low `MAN_W` bits. The exponent is biased by 2^(EXP_W-1)-1. For a normal number the hidden one is restored, and the block works out a shift from the unbiased exponent and the radix point. A single shifter then moves the significand left or right by that amount. Bits below the fixed-point LSB are dropped, and the result is negated when the sign is set. Zeros and denormals give zero. Infinities, NaNs and magnitudes that do not fit raise an overflow flag and saturate the output. A single output register gives one cycle of latency. The defaults cover single precision into 32 bits, and other parameter sets cover formats such as 64 bits with 47 fraction bits or 51 bits with 30 fraction bits.

Top module: `flt2fix`

## Requirements
- R1: `out_vld` is high exactly one clock after `in_vld` was high. Reset clears `out_vld`, `out_fix` and `out_ovf`.
- R2: For a normal, positive input in range, `out_fix` equals floor(x * 2^rp), where rp is the radix point. Fraction bits below the LSB are truncated. Field layout: sign is bit FLT_W-1, exponent is bits FLT_W-2..MAN_W, mantissa is bits MAN_W-1..0, and the bias is 2^(EXP_W-1)-1.
- R3: An exponent field of zero (signed zero or a denormal) gives `out_fix` = 0 with `out_ovf` low.
- R4: A negative normal input in range gives the two's complement of the truncated magnitude, so rounding is toward zero.
- R5: With `RP_FIXED` negative, the radix point is taken from `in_rp` for each conversion. With `RP_FIXED` zero or greater, the radix point is that constant and `in_rp` has no effect.
- R6: An exponent field of all ones (infinity or NaN) sets `out_ovf`.
- R7: On overflow, `out_fix` saturates to 2^(FIX_W-1)-1 when the sign bit is clear and to -2^(FIX_W-1) when it is set.
- R8: A positive magnitude of 2^(FIX_W-1) or more after scaling sets `out_ovf`. A negative magnitude sets it only above 2^(FIX_W-1), so -2^(FIX_W-1) converts exactly with the flag low.
- R9: While `in_vld` is low, `out_fix` and `out_ovf` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Conversion request |
| in_flt | input | FLT_W | Floating-point word |
| in_rp | input | RP_W | Run-time radix point (fraction bits) |
| out_vld | output | 1 | Result valid |
| out_fix | output | FIX_W | Fixed-point result |
| out_ovf | output | 1 | Overflow / special-value exception |

## Verification
Some behaviours are checked by assertions on every cycle:
- the one-cycle valid timing;
- the zero result for a zero exponent field;
- the flag for an all-ones exponent;
- that any flagged result is one of the two saturation values;
- that a positive input never yields a negative word;
- that the outputs hold while idle.

Other behaviours can only be shown by the bench scenarios, which compare results against an independent repeated-doubling model:
- the exact shifted and truncated values;
- the boundary at 2^(FIX_W-1) for each sign;
- truncation toward zero for negatives;
- that a parameter-fixed radix point ignores `in_rp`.

// File: rtl/flt2fix.sv
module flt2fix #(
  parameter int FLT_W    = 32,
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int FIX_W    = 32,
  parameter int RP_W     = 6,
  parameter int RP_FIXED = -1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [FLT_W-1:0] in_flt,
  input  logic [RP_W-1:0]  in_rp,
  output logic             out_vld,
  output logic [FIX_W-1:0] out_fix,
  output logic             out_ovf
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int MAG_W = MAN_W + 1 + FIX_W;
  localparam int TOP_W = MAG_W - FIX_W + 1;
  localparam logic [FIX_W-1:0] SAT_POS = {1'b0, {(FIX_W-1){1'b1}}};
  localparam logic [FIX_W-1:0] SAT_NEG = {1'b1, {(FIX_W-1){1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic [RP_W-1:0]  rp_sel;

  assign sgn = in_flt[FLT_W-1];
  assign ex  = in_flt[FLT_W-2 -: EXP_W];
  assign man = in_flt[MAN_W-1:0];

  generate
    if (RP_FIXED < 0) begin : g_rp_port
      assign rp_sel = in_rp;
    end else begin : g_rp_param
      assign rp_sel = RP_W'(RP_FIXED);
    end
  endgenerate

  logic is_zero, is_spec;
  assign is_zero = (ex == '0);
  assign is_spec = &ex;

  int               k;
  logic             big_left;
  logic [MAG_W-1:0] mag;

  always_comb begin
    k        = int'(ex) + int'(rp_sel) - (BIAS + MAN_W);
    big_left = 1'b0;
    mag      = '0;
    if (k >= FIX_W)  big_left = 1'b1;
    else if (k >= 0) mag = MAG_W'({1'b1, man}) << k;
    else             mag = MAG_W'({1'b1, man}) >> (-k);
  end

  logic [TOP_W-1:0] top;
  logic             rest_nz, rng_ovf, ovf;
  logic [FIX_W-1:0] res;

  assign top     = mag[MAG_W-1:FIX_W-1];
  assign rest_nz = |mag[FIX_W-2:0];
  assign rng_ovf = big_left | (sgn ? (|top && (top != TOP_W'(1) || rest_nz)) : |top);
  assign ovf     = !is_zero && (is_spec || rng_ovf);

  always_comb begin
    if (is_zero)  res = '0;
    else if (ovf) res = sgn ? SAT_NEG : SAT_POS;
    else if (sgn) res = -mag[FIX_W-1:0];
    else          res = mag[FIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_fix <= '0;
      out_ovf <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_fix <= res;
        out_ovf <= ovf;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R1
  AST_ZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_flt[FLT_W-2 -: EXP_W] == '0) |=> (out_fix == '0 && !out_ovf)); // R3
  AST_SPECIAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && &in_flt[FLT_W-2 -: EXP_W]) |=> out_ovf); // R6
  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_ovf) |-> (out_fix == SAT_POS || out_fix == SAT_NEG)); // R7
  AST_POS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_flt[FLT_W-1]) |=> !out_fix[FIX_W-1]); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_fix) && $stable(out_ovf))); // R9
endmodule

// File: tb/flt2fix_test.sv
module flt2fix_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] in_flt = '0;
  logic [5:0]  in_rp = '0;
  logic        out_vld, out_ovf, p_vld, p_ovf;
  logic [31:0] out_fix, p_fix;

  always #2.5 clk = ~clk;

  flt2fix uut (.clk, .rst_n, .in_vld, .in_flt, .in_rp,
    .out_vld(out_vld), .out_fix(out_fix), .out_ovf(out_ovf));
  flt2fix #(.RP_FIXED(20)) uut_p (.clk, .rst_n, .in_vld, .in_flt, .in_rp,
    .out_vld(p_vld), .out_fix(p_fix), .out_ovf(p_ovf));

  typedef struct {
    logic [31:0] fix;
    logic        ovf;
    logic [31:0] pfix;
    logic        povf;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] last_fix;
  logic        last_ovf;
  bit          started = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic logic [31:0] mkf(input bit s, input int e, input int m);
    return {s, e[7:0], m[22:0]};
  endfunction

  function automatic void model(input logic [31:0] f, input int rp,
                                output logic [31:0] fx, output logic ov);
    int           e, p;
    bit           big;
    logic [127:0] v, lim;
    e   = int'(f[30:23]);
    big = 0;
    if (e == 0) begin
      fx = 0; ov = 0;
    end else if (e == 255) begin
      ov = 1; fx = f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end else begin
      v = {104'd0, 1'b1, f[22:0]};
      p = e - 127 + rp - 23;
      for (int i = 0; i < p; i++) begin
        v = v * 2;
        if (v > 128'h1_0000_0000) begin big = 1; break; end
      end
      for (int i = 0; i < -p; i++) v = v / 2;
      lim = f[31] ? 128'h8000_0000 : 128'h7FFF_FFFF;
      if (big || v > lim) begin
        ov = 1; fx = f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end else begin
        ov = 0; fx = f[31] ? -v[31:0] : v[31:0];
      end
    end
  endfunction

  task automatic drive(input logic [31:0] f, input int rp, input string tag);
    item_t it;
    model(f, rp, it.fix, it.ovf);
    model(f, 20, it.pfix, it.povf);
    it.tag = tag;
    sb.push_back(it);
    in_vld = 1'b1;
    in_flt = f;
    in_rp  = rp[5:0];
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic expect_fix(input logic [31:0] f, input int rp, input logic [31:0] want,
                            input logic wovf, input string tag);
    logic [31:0] mf;
    logic        mo;
    model(f, rp, mf, mo);
    chk({tag, " model-fix"}, mf, want);
    chk({tag, " model-ovf"}, {31'd0, mo}, {31'd0, wovf});
    drive(f, rp, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld) begin
        item_t it;
        if (sb.size() == 0) begin
          chk("R1 unexpected out_vld", 32'd1, 32'd0);
        end else begin
          it = sb.pop_front();
          chk({it.tag, " fix"}, out_fix, it.fix);
          chk({it.tag, " ovf"}, {31'd0, out_ovf}, {31'd0, it.ovf});
          chk({it.tag, " R5 param-rp fix"}, p_fix, it.pfix);
          chk({it.tag, " R5 param-rp ovf"}, {31'd0, p_ovf}, {31'd0, it.povf});
          chk("R1 twin valid", {31'd0, p_vld}, 32'd1);
        end
        last_fix = out_fix;
        last_ovf = out_ovf;
        started  = 1;
      end else if (started) begin
        chk("R9 hold fix", out_fix, last_fix);
        chk("R9 hold ovf", {31'd0, out_ovf}, {31'd0, last_ovf});
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 reset vld", {31'd0, out_vld}, 32'd0);
        chk("R1 reset fix", out_fix, 32'd0);
        chk("R1 reset ovf", {31'd0, out_ovf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_fix(mkf(0, 127, 0), 20, 32'h0010_0000, 0, "R2 one");
        expect_fix(mkf(1, 127, 22'h0 | (1 << 22)), 20, 32'hFFE8_0000, 0, "R4 minus1.5");
        expect_fix(mkf(0, 0, 0), 20, 32'h0, 0, "R3 zero");
        expect_fix(mkf(1, 0, 0), 20, 32'h0, 0, "R3 negzero");
        expect_fix(mkf(0, 0, 1), 20, 32'h0, 0, "R3 denormal");
        expect_fix(mkf(0, 255, 0), 20, 32'h7FFF_FFFF, 1, "R6 posinf");
        expect_fix(mkf(1, 255, 0), 20, 32'h8000_0000, 1, "R7 neginf");
        expect_fix(mkf(0, 255, 5), 3, 32'h7FFF_FFFF, 1, "R6 nan");
        expect_fix(mkf(0, 138, 0), 20, 32'h7FFF_FFFF, 1, "R8 pos2048");
        expect_fix(mkf(1, 138, 0), 20, 32'h8000_0000, 0, "R8 neg2048");
        expect_fix(mkf(0, 137, 23'h7FFFFF), 20, 32'h7FFF_FF80, 0, "R8 below");
        expect_fix(mkf(1, 138, 1), 20, 32'h8000_0000, 1, "R7 negover");
        expect_fix(mkf(0, 106, 0), 20, 32'h0, 0, "R2 tiny");
        expect_fix(mkf(0, 107, 23'h600000), 20, 32'h1, 0, "R2 trunc");
        expect_fix(mkf(0, 128, 23'h700000), 0, 32'h3, 0, "R5 rp0 pos");
        expect_fix(mkf(1, 128, 23'h700000), 0, 32'hFFFF_FFFD, 0, "R4 rp0 neg");
        expect_fix(mkf(0, 126, 0), 31, 32'h4000_0000, 0, "R5 rp31");
        expect_fix(mkf(0, 254, 0), 20, 32'h7FFF_FFFF, 1, "R8 huge");
        repeat (3) @(negedge clk);
        for (int n = 0; n < 300; n++) begin
          int e, rp, sel;
          sel = $urandom_range(0, 19);
          e   = (sel == 0) ? 255 : (sel == 1) ? 0 : $urandom_range(100, 170);
          rp  = $urandom_range(0, 63);
          drive(mkf($urandom_range(0, 1), e, $urandom), rp, "R2 random");
          if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R1 scoreboard drained", sb.size(), 32'd0);
      end
      begin
        repeat (20000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule